// File: doc/BRIEF.md
# Two-Bank Interleaved DRAM Controller

This block sits between a 32-bit processor bus and two 32-bit-wide DRAM banks built from 64Kx4 devices. The processor asks for an access with a one-clock start strobe, a word address, a write flag and four active-high byte enables. The controller then runs a fixed three-clock sequence on the DRAM pins. The low word-address bit picks one of the two banks, so consecutive words alternate between them.

Each bank has its own row strobe. The four column strobes are shared by both banks, one per byte lane. A single write enable and a single output enable go to every device. A partial-word write is made by leaving the column strobes of the unused lanes high. The write enable is never split by lane. This way a lane that takes no part in the access never drives the data bus.

All DRAM-side outputs come straight from flip-flops. The row and column halves of the address share one 8-bit multiplexed bus.

Top module: `dram_ilv_ctrl`

## Requirements
- R1: While reset is asserted and on the first clock after it, every row strobe, column strobe, write enable and output enable is high, ready is low, and the multiplexed address is zero.
- R2: Address input bit 0 (processor A2) selects the bank. A value of 0 drives `dram_ras_n[0]` low and 1 drives `dram_ras_n[1]` low. At no time are both row strobes low.
- R3: Column strobe `dram_cas_n[k]` is driven low only in a cycle whose byte enable `cpu_be[k]` was 1 at the start. Lane 0 serves data bits 7..0 and lane 3 serves bits 31..24. A lane whose enable was 0 keeps its column strobe high for the whole cycle, so its devices stay in high impedance. A column strobe is never low while both row strobes are high.
- R4: In the column and ready clocks, `dram_we_n` is low for a write and `dram_oe_n` is low for a read. Both are high at every other time, and they are never low together.
- R5: When a row strobe falls, the multiplexed bus carries the row address, which is address input bits 8..1 (processor A10..A3). One clock later it carries the column address, which is address input bits 16..9 (processor A18..A11). The bus holds that value while the column strobes stay low.
- R6: A start sampled at a clock edge while idle sets off this sequence. That edge drops the selected row strobe. The next edge drops the column strobes and WE or OE. The edge after that raises ready for exactly one clock. The following edge returns every strobe high with ready low.
- R7: A start strobe that arrives while a cycle is running is ignored. The bank, address, byte enables and write flag of the running cycle stay unchanged.
- R8: After ready, all row and column strobes stay high for at least one clock. A start held high without a gap gives one access every four clocks.
- R9: A cycle whose byte enables are all 0 still runs the row sequence and returns ready. It drops no column strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_start | input | 1 | Access request, sampled at the clock edge |
| cpu_addr | input | 17 | Word address. Bit 0 is processor A2 and bit 16 is A18 |
| cpu_wr | input | 1 | 1 for a write, 0 for a read |
| cpu_be | input | 4 | Active-high byte enables, bit k for lane k |
| cpu_ready | output | 1 | One-clock completion pulse |
| dram_ras_n | output | 2 | Row strobes, one per bank, active low |
| dram_cas_n | output | 4 | Column strobes, one per byte lane, active low |
| dram_we_n | output | 1 | Shared write enable, active low |
| dram_oe_n | output | 1 | Shared output enable, active low |
| dram_ma | output | 8 | Multiplexed row/column address |

## Verification
A phase register that slips or sticks shows up on the strobe pins within one clock. Ready would then arrive early or late, or a strobe would still be low on the clock after ready. A request register that takes in a start during a running cycle shows up at the next column clock, as a wrong bank, wrong lane set or wrong column address. Each pin is therefore compared against the expected value on every clock of every access, while a different request is held on the inputs.

// File: rtl/dram_ilv_pkg.sv
package dram_ilv_pkg;

   // Access phase. Order matters: each state follows the previous one.
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ROW  = 2'd1,
      PH_COL  = 2'd2,
      PH_DONE = 2'd3
   } phase_t;

   function automatic logic ras_phase(input phase_t p);
      return p != PH_IDLE;
   endfunction

   function automatic logic cas_phase(input phase_t p);
      return (p == PH_COL) || (p == PH_DONE);
   endfunction

endpackage

// File: rtl/dram_ilv_seq.sv
// Access sequencer: takes a request only when idle and holds it for the cycle.
module dram_ilv_seq
   import dram_ilv_pkg::*;
#(
   parameter int AW    = 17,
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [AW-1:0]    addr,
   input  logic             wr,
   input  logic [LANES-1:0] be,
   output phase_t           ph_d,
   output logic [AW-1:0]    addr_d,
   output logic             wr_d,
   output logic [LANES-1:0] be_d
);

   phase_t           ph_q;
   logic [AW-1:0]    addr_q;
   logic             wr_q;
   logic [LANES-1:0] be_q;
   logic             accept;

   // R7: requests are taken only from idle
   assign accept = start && (ph_q == PH_IDLE);

   always_comb begin
      unique case (ph_q)
         PH_IDLE: ph_d = accept ? PH_ROW : PH_IDLE;
         PH_ROW:  ph_d = PH_COL;
         PH_COL:  ph_d = PH_DONE;
         default: ph_d = PH_IDLE;
      endcase
   end

   assign addr_d = accept ? addr : addr_q;
   assign wr_d   = accept ? wr   : wr_q;
   assign be_d   = accept ? be   : be_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         addr_q <= '0;
         wr_q   <= 1'b0;
         be_q   <= '0;
      end else begin
         ph_q   <= ph_d;
         addr_q <= addr_d;
         wr_q   <= wr_d;
         be_q   <= be_d;
      end
   end

endmodule

// File: rtl/dram_ilv_amux.sv
// Registered row/column multiplexer for the DRAM address pins.
module dram_ilv_amux
   import dram_ilv_pkg::*;
#(
   parameter int MUX_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  phase_t             ph_d,
   input  logic [2*MUX_W-1:0] rc_d,   // {column, row}
   output logic [MUX_W-1:0]   ma_q
);

   logic [MUX_W-1:0] row_part;
   logic [MUX_W-1:0] col_part;

   assign row_part = rc_d[MUX_W-1:0];
   assign col_part = rc_d[2*MUX_W-1:MUX_W];

   // R5: row address with the row strobe, column address from the column phase on
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ma_q <= '0;
      end else begin
         unique case (ph_d)
            PH_ROW:          ma_q <= row_part;
            PH_COL, PH_DONE: ma_q <= col_part;
            default:         ma_q <= ma_q;
         endcase
      end
   end

endmodule

// File: rtl/dram_ilv_strb.sv
// Strobe flops: one row strobe per bank, one column strobe per lane,
// shared write and output enables, and the ready pulse.
module dram_ilv_strb
   import dram_ilv_pkg::*;
#(
   parameter int BSW   = 1,
   parameter int LANES = 4,
   localparam int NBANK = 1 << BSW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  phase_t           ph_d,
   input  logic [BSW-1:0]   bank_d,
   input  logic             wr_d,
   input  logic [LANES-1:0] be_d,
   output logic [NBANK-1:0] ras_n,
   output logic [LANES-1:0] cas_n,
   output logic             we_n,
   output logic             oe_n,
   output logic             ready
);

   logic ras_on;
   logic cas_on;

   assign ras_on = ras_phase(ph_d);
   assign cas_on = cas_phase(ph_d);

   // R2: only the addressed bank sees its row strobe
   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ras_n[b] <= 1'b1;
         else        ras_n[b] <= !(ras_on && (bank_d == BSW'(b)));
      end
   end

   // R3/R9: a lane strobes only if its byte enable was set
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cas_n[l] <= 1'b1;
         else        cas_n[l] <= !(cas_on && be_d[l]);
      end
   end

   // R4 and R6
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_n  <= 1'b1;
         oe_n  <= 1'b1;
         ready <= 1'b0;
      end else begin
         we_n  <= !(cas_on && wr_d);
         oe_n  <= !(cas_on && !wr_d);
         ready <= (ph_d == PH_DONE);
      end
   end

endmodule

// File: rtl/dram_ilv_ctrl.sv
// Two-bank interleaved DRAM controller, three clocks per access.
module dram_ilv_ctrl
   import dram_ilv_pkg::*;
#(
   parameter int BSW   = 1,   // bank-select bits taken from the low word address
   parameter int MUX_W = 8,   // multiplexed address width
   parameter int LANES = 4,   // byte lanes
   localparam int NBANK = 1 << BSW,
   localparam int AW    = BSW + 2 * MUX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_start,
   input  logic [AW-1:0]    cpu_addr,
   input  logic             cpu_wr,
   input  logic [LANES-1:0] cpu_be,
   output logic             cpu_ready,
   output logic [NBANK-1:0] dram_ras_n,
   output logic [LANES-1:0] dram_cas_n,
   output logic             dram_we_n,
   output logic             dram_oe_n,
   output logic [MUX_W-1:0] dram_ma
);

   if (BSW < 1 || BSW > 3) begin : g_bad_bsw
      $error("dram_ilv_ctrl: BSW must lie in 1..3");
   end
   if (MUX_W < 1) begin : g_bad_mux
      $error("dram_ilv_ctrl: MUX_W must be positive");
   end
   if (LANES < 1 || LANES > 8) begin : g_bad_lanes
      $error("dram_ilv_ctrl: LANES must lie in 1..8");
   end

   phase_t           ph_d;
   logic [AW-1:0]    addr_d;
   logic             wr_d;
   logic [LANES-1:0] be_d;

   dram_ilv_seq #(.AW(AW), .LANES(LANES)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (cpu_start),
      .addr   (cpu_addr),
      .wr     (cpu_wr),
      .be     (cpu_be),
      .ph_d   (ph_d),
      .addr_d (addr_d),
      .wr_d   (wr_d),
      .be_d   (be_d)
   );

   dram_ilv_amux #(.MUX_W(MUX_W)) u_amux (
      .clk   (clk),
      .rst_n (rst_n),
      .ph_d  (ph_d),
      .rc_d  (addr_d[AW-1:BSW]),
      .ma_q  (dram_ma)
   );

   dram_ilv_strb #(.BSW(BSW), .LANES(LANES)) u_strb (
      .clk    (clk),
      .rst_n  (rst_n),
      .ph_d   (ph_d),
      .bank_d (addr_d[BSW-1:0]),
      .wr_d   (wr_d),
      .be_d   (be_d),
      .ras_n  (dram_ras_n),
      .cas_n  (dram_cas_n),
      .we_n   (dram_we_n),
      .oe_n   (dram_oe_n),
      .ready  (cpu_ready)
   );

endmodule

// File: rtl/dram_ilv_chk.sv
// Port-level checker, bound into every dram_ilv_ctrl.
module dram_ilv_chk #(
   parameter int BSW   = 1,
   parameter int MUX_W = 8,
   parameter int LANES = 4,
   localparam int NBANK = 1 << BSW,
   localparam int AW    = BSW + 2 * MUX_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_start,
   input logic [AW-1:0]    cpu_addr,
   input logic             cpu_ready,
   input logic [NBANK-1:0] dram_ras_n,
   input logic [LANES-1:0] dram_cas_n,
   input logic             dram_we_n,
   input logic             dram_oe_n,
   input logic [MUX_W-1:0] dram_ma
);

   // R2: never two banks at once
   p_one_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~dram_ras_n) <= 1);

   // R2 and R5: a falling row strobe follows a sampled start for its own bank,
   // and the bus carries that start's row address
   for (genvar b = 0; b < NBANK; b++) begin : g_rasb
      p_ras_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(dram_ras_n[b]) |->
            ($past(cpu_start) && ($past(cpu_addr[BSW-1:0]) == BSW'(b))));
      p_row_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(dram_ras_n[b]) |-> (dram_ma == $past(cpu_addr[BSW +: MUX_W])));
   end

   // R3: no column strobe without a row strobe
   p_cas_in_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(&dram_cas_n) |-> !(&dram_ras_n));

   // R4: write and output enable never together, never outside a row cycle
   p_we_oe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dram_we_n && !dram_oe_n));
   p_we_in_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_we_n || !dram_oe_n) |-> !(&dram_ras_n));

   // R5: column address stable while the column strobes stay low
   p_ma_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&dram_cas_n) && $past(!(&dram_cas_n))) |-> $stable(dram_ma));

   // R6: ready lasts one clock and comes inside a row cycle
   p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready);
   p_ready_in_ras_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !(&dram_ras_n));

   // R8: everything released on the clock after ready
   p_precharge_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> ((&dram_ras_n) && (&dram_cas_n) && dram_we_n && dram_oe_n));

endmodule

bind dram_ilv_ctrl dram_ilv_chk #(.BSW(BSW), .MUX_W(MUX_W), .LANES(LANES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_start  (cpu_start),
   .cpu_addr   (cpu_addr),
   .cpu_ready  (cpu_ready),
   .dram_ras_n (dram_ras_n),
   .dram_cas_n (dram_cas_n),
   .dram_we_n  (dram_we_n),
   .dram_oe_n  (dram_oe_n),
   .dram_ma    (dram_ma)
);

// File: tb/dram_ilv_ctrl_tb_top.sv
module dram_ilv_ctrl_tb_top;

   localparam int BSW   = 1;
   localparam int MUX_W = 8;
   localparam int LANES = 4;
   localparam int AW    = BSW + 2 * MUX_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cpu_start = 1'b0;
   logic [AW-1:0]    cpu_addr = '0;
   logic             cpu_wr = 1'b0;
   logic [LANES-1:0] cpu_be = '0;
   logic             cpu_ready;
   logic [1:0]       dram_ras_n;
   logic [LANES-1:0] dram_cas_n;
   logic             dram_we_n;
   logic             dram_oe_n;
   logic [MUX_W-1:0] dram_ma;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   dram_ilv_ctrl #(.BSW(BSW), .MUX_W(MUX_W), .LANES(LANES)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_start  (cpu_start),
      .cpu_addr   (cpu_addr),
      .cpu_wr     (cpu_wr),
      .cpu_be     (cpu_be),
      .cpu_ready  (cpu_ready),
      .dram_ras_n (dram_ras_n),
      .dram_cas_n (dram_cas_n),
      .dram_we_n  (dram_we_n),
      .dram_oe_n  (dram_oe_n),
      .dram_ma    (dram_ma)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // All outputs at rest: strobes high, ready low
   task automatic chk_rest(input string tag);
      chk(dram_ras_n == 2'b11, tag, 32'(dram_ras_n), 32'h3);
      chk(dram_cas_n == 4'hF, tag, 32'(dram_cas_n), 32'hF);
      chk(dram_we_n && dram_oe_n, tag, {30'd0, dram_we_n, dram_oe_n}, 32'h3);
      chk(cpu_ready == 1'b0, tag, 32'(cpu_ready), 32'h0);
   endtask

   // One access, entered at a negedge. A different request is held on the
   // inputs for the whole cycle. Returns at the negedge after release.
   task automatic access(input logic [AW-1:0] a, input bit w, input logic [3:0] be,
                         input bit keep);
      logic [1:0]    exp_ras;
      logic [AW-1:0] junk;
      exp_ras = a[0] ? 2'b01 : 2'b10;
      junk    = a ^ {AW{1'b1}};
      cpu_start = 1'b1; cpu_addr = a; cpu_wr = w; cpu_be = be;
      tick();
      // row clock
      chk(dram_ras_n == exp_ras, "R2 bank select", 32'(dram_ras_n), 32'(exp_ras));
      chk(dram_ma == a[8:1], "R5 row address", 32'(dram_ma), 32'(a[8:1]));
      chk(dram_cas_n == 4'hF, "R6 no CAS in row clock", 32'(dram_cas_n), 32'hF);
      chk(dram_we_n && dram_oe_n, "R4 enables idle in row clock",
          {30'd0, dram_we_n, dram_oe_n}, 32'h3);
      chk(!cpu_ready, "R6 ready low in row clock", 32'(cpu_ready), 32'h0);
      // R7: a conflicting request during the cycle
      cpu_addr = junk; cpu_wr = ~w; cpu_be = ~be; cpu_start = 1'b1;
      tick();
      // column clock
      chk(dram_ras_n == exp_ras, "R7 bank kept", 32'(dram_ras_n), 32'(exp_ras));
      chk(dram_cas_n == ~be, "R3 lane strobes", 32'(dram_cas_n), 32'(~be));
      chk(dram_ma == a[16:9], "R5 column address", 32'(dram_ma), 32'(a[16:9]));
      chk(dram_we_n == !w, "R4 write enable", 32'(dram_we_n), 32'(!w));
      chk(dram_oe_n == w, "R4 output enable", 32'(dram_oe_n), 32'(w));
      chk(!cpu_ready, "R6 ready low in column clock", 32'(cpu_ready), 32'h0);
      tick();
      // ready clock
      chk(cpu_ready, "R6 ready pulse", 32'(cpu_ready), 32'h1);
      chk(dram_ras_n == exp_ras, "R6 RAS held in ready clock", 32'(dram_ras_n),
          32'(exp_ras));
      chk(dram_cas_n == ~be, "R3 lanes held", 32'(dram_cas_n), 32'(~be));
      chk(dram_ma == a[16:9], "R5 column held", 32'(dram_ma), 32'(a[16:9]));
      chk(dram_we_n == !w, "R7 write flag kept", 32'(dram_we_n), 32'(!w));
      if (be == 4'h0)
         chk(dram_cas_n == 4'hF && cpu_ready, "R9 empty enables",
             {27'd0, cpu_ready, dram_cas_n}, 32'h1F);
      if (!keep) cpu_start = 1'b0;
      tick();
      // release clock (the caller may already present the next request)
      chk_rest("R8 precharge clock");
   endtask

   initial begin
      #0;
      repeat (3) @(negedge clk);
      chk_rest("R1 reset state");
      chk(dram_ma == '0, "R1 reset address", 32'(dram_ma), 32'h0);
      cpu_start = 1'b1;   // ignored during reset
      @(negedge clk);
      chk_rest("R1 start under reset");
      cpu_start = 1'b0;
      rst_n = 1'b1;
      tick();
      chk_rest("R1 after reset release");
      chk(dram_ma == '0, "R1 address after release", 32'(dram_ma), 32'h0);

      // Sweep: all byte-enable patterns x read/write x bank, back to back.
      for (int i = 0; i < 64; i++) begin
         logic [AW-1:0] a;
         a = AW'((i * 2749 + 5) * 37);
         if (i == 62) a = '0;
         if (i == 63) a = '1;
         a[0] = i[5];
         access(a, i[4], i[3:0], (i != 63));
      end

      // R8: with start high without a gap, the next row strobe
      // falls on the clock right after the release clock
      access(17'h0A5A4, 1'b1, 4'b1010, 1'b1);
      cpu_addr = 17'h13C3B; cpu_wr = 1'b0; cpu_be = 4'hF;
      tick();
      chk(dram_ras_n == 2'b01, "R8 back-to-back RAS", 32'(dram_ras_n), 32'h1);
      cpu_start = 1'b0;
      repeat (3) tick();

      // R6: no start means no cycle
      for (int k = 0; k < 6; k++) begin
         tick();
         chk_rest("R6 idle without start");
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule